// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the DMA-side engine that stores received Ethernet frames into a ring of buffer descriptors held in a word-wide on-chip memory. Each descriptor takes two consecutive words. The first word carries a 16-bit status field and a 16-bit byte count. The second word is the word address of the frame buffer. Software hands a descriptor to the engine by setting its EMPTY flag. The engine fills the buffer, writes back the count and status with EMPTY cleared, and so returns the descriptor to software.

The ring has no fixed length. The descriptor whose WRAP flag is set is the last one, and after it the engine returns to the ring base address. The engine reads each descriptor ahead of the frame it will hold. When it finds a descriptor that software still owns, it stops and waits for a task-enable strobe. The receive MAC is modelled as a byte stream with start, end and error marks. A frame that begins while no descriptor is ready is dropped and counted.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the engine is stalled (`stalled`=1), issues no memory request, `drop_count` is 0, and the current descriptor address equals `ring_base`; nothing is fetched until `kick` is pulsed.
- R2: Descriptor layout: word 0 holds status in bits 31:16 and byte count in bits 15:0; word 1 holds the buffer word address. Status bits: EMPTY=15, WRAP=13, LAST=11, ERR=1. The engine never writes word 1.
- R3: A `kick` while stalled makes the engine read the current descriptor; if EMPTY is set the engine becomes ready (`stalled`=0) and writes nothing until a frame arrives.
- R4: Frame bytes are packed four per word, first byte in bits 7:0, into consecutive words starting at the buffer address; unused upper lanes of the final word are written as zero.
- R5: At frame end, word 0 is rewritten with the byte count including the 4-byte frame check sequence, EMPTY cleared, LAST set, WRAP kept, and ERR equal to `rx_err` on the last byte; other status bits are zero; `frame_done` pulses for exactly one cycle.
- R6: After a descriptor completes, the next one is at the current address plus 2, or at `ring_base` when the completed one had WRAP set, and it is fetched without a new `kick`.
- R7: A frame longer than MAX_LEN (default 1518) bytes stores only its first MAX_LEN bytes, reports count MAX_LEN and sets ERR; nothing beyond the truncated buffer is written.
- R8: A frame whose start byte arrives while the engine is not ready is dropped: no memory write, and `drop_count` rises by exactly one.
- R9: On reading a descriptor with EMPTY clear, the engine stalls and writes nothing; a `kick` while that descriptor is still owned by software leaves it stalled; after software sets EMPTY, a `kick` resumes reception into that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of the first descriptor |
| kick | input | 1 | Task-enable strobe that restarts a stalled engine |
| rx_valid | input | 1 | Byte valid on the receive stream |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| stalled | output | 1 | Engine waiting for a kick |
| frame_done | output | 1 | One-cycle pulse as a descriptor is handed back |
| drop_count | output | CW | Number of dropped frames, wrapping |

## Verification
Frames of length 60 to 63 fill every lane position of the last buffer word, so they show whether the zero fill and the count agree. A one-byte frame checks start and end on the same byte. Error-flagged frames check that ERR comes from the end mark and does not leak into the next descriptor. Six frames across a three-entry ring show whether the engine follows the WRAP flag back to the base. A ring filled without freeing tells apart a stall, a dropped frame and a resume that needs the descriptor freed. A 1530-byte frame with a sentinel word after the buffer shows whether truncation stops both the writes and the count.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  // status bit positions inside the 16-bit status half of descriptor word 0
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_LAST  = 11;
  localparam int ST_ERR   = 1;

  typedef enum logic [3:0] {
    S_STALL, S_FETCH, S_WAIT0, S_CAP0, S_CAP1,
    S_ARMED, S_RECV, S_FLUSH, S_WDESC
  } rxr_state_t;
endpackage

// File: rtl/rxr_pack.sv
`timescale 1ns/1ps
// Gathers bytes into memory words, lowest lane first.
module rxr_pack #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    byte_in,
  output logic [DW-1:0] full_word,
  output logic          fire,
  output logic [DW-1:0] part_word,
  output logic          part_any
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  logic [DW-1:0] acc;
  logic [LW-1:0] lane;

  always_comb begin
    full_word = acc;
    full_word[8*int'(lane) +: 8] = byte_in;
  end

  assign fire      = push && (lane == LW'(NB - 1));
  assign part_word = acc;
  assign part_any  = (lane != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      lane <= '0;
    end else if (push) begin
      acc  <= fire ? '0 : full_word;
      lane <= lane + LW'(1);
    end
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
`timescale 1ns/1ps
// Current descriptor address; follows the wrap flag back to the base.
module rxr_ring_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)          cur <= base;
    else if (advance) cur <= wrap ? base : cur + AW'(2);
  end
endmodule

// File: rtl/rxr_drop_cnt.sv
`timescale 1ns/1ps
module rxr_drop_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (hit) count <= count + CW'(1);
  end
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int MAX_LEN = 1518,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic          kick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          stalled,
  output logic          frame_done,
  output logic [CW-1:0] drop_count
);
  localparam int SW = DW / 2;

  rxr_state_t    state;
  logic [AW-1:0] cur;
  logic [DW-1:0] buf_q;
  logic [AW-1:0] widx;
  logic [SW-1:0] len_q;
  logic          wrap_q, emp_q, err_q, trunc_q;
  logic          req_q, we_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic          take, room, push, fire, part_any, drop_hit, adv, clr_pack;
  logic [DW-1:0] full_word, part_word;
  logic [SW-1:0] stat_out;
  logic [AW-1:0] data_addr;

  assign take = rx_valid && ((state == S_ARMED && rx_sof) || state == S_RECV);
  assign room = (len_q < SW'(MAX_LEN));
  assign push = take && room;
  assign drop_hit = rx_valid && rx_sof && (state != S_ARMED) && (state != S_RECV);
  assign adv = (state == S_WDESC);
  assign clr_pack = (state == S_WDESC);
  assign data_addr = AW'(buf_q + DW'(widx));

  always_comb begin
    stat_out = '0;
    stat_out[ST_WRAP] = wrap_q;
    stat_out[ST_LAST] = 1'b1;
    stat_out[ST_ERR]  = err_q | trunc_q;
  end

  rxr_pack #(.DW(DW)) pack_i (
    .clk(clk), .rst(rst), .clr(clr_pack), .push(push), .byte_in(rx_data),
    .full_word(full_word), .fire(fire), .part_word(part_word), .part_any(part_any)
  );

  rxr_ring_ptr #(.AW(AW)) ptr_i (
    .clk(clk), .rst(rst), .base(ring_base), .advance(adv), .wrap(wrap_q), .cur(cur)
  );

  rxr_drop_cnt #(.CW(CW)) drop_i (
    .clk(clk), .rst(rst), .hit(drop_hit), .count(drop_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_STALL;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      buf_q   <= '0;
      widx    <= '0;
      len_q   <= '0;
      wrap_q  <= 1'b0;
      emp_q   <= 1'b0;
      err_q   <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_STALL: if (kick) state <= S_FETCH;
        S_FETCH: begin
          req_q  <= 1'b1;
          addr_q <= cur;
          state  <= S_WAIT0;
        end
        S_WAIT0: begin
          req_q  <= 1'b1;
          addr_q <= cur + AW'(1);
          state  <= S_CAP0;
        end
        S_CAP0: begin
          wrap_q <= mem_rdata[SW + ST_WRAP];
          emp_q  <= mem_rdata[SW + ST_EMPTY];
          state  <= S_CAP1;
        end
        S_CAP1: begin
          buf_q   <= mem_rdata;
          widx    <= '0;
          len_q   <= '0;
          err_q   <= 1'b0;
          trunc_q <= 1'b0;
          state   <= emp_q ? S_ARMED : S_STALL;
        end
        S_ARMED, S_RECV: begin
          if (take) begin
            if (room) len_q <= len_q + SW'(1);
            else      trunc_q <= 1'b1;
            if (fire) begin
              req_q   <= 1'b1;
              we_q    <= 1'b1;
              addr_q  <= data_addr;
              wdata_q <= full_word;
              widx    <= widx + AW'(1);
            end
            if (rx_eof) begin
              err_q <= rx_err;
              state <= S_FLUSH;
            end else begin
              state <= S_RECV;
            end
          end
        end
        S_FLUSH: begin
          if (part_any) begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            addr_q  <= data_addr;
            wdata_q <= part_word;
          end
          state <= S_WDESC;
        end
        S_WDESC: begin
          req_q   <= 1'b1;
          we_q    <= 1'b1;
          addr_q  <= cur;
          wdata_q <= {stat_out, len_q};
          done_q  <= 1'b1;
          state   <= S_FETCH;
        end
        default: state <= S_STALL;
      endcase
    end
  end

  assign mem_req    = req_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign frame_done = done_q;
  assign stalled    = (state == S_STALL);
endmodule

// File: rtl/rxr_ring_writer_chk.sv
`timescale 1ns/1ps
module rxr_ring_writer_chk
  import rxr_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CW      = 8,
  parameter int MAX_LEN = 1518
) (
  input logic          clk,
  input logic          rst,
  input logic          stalled,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          frame_done,
  input logic [CW-1:0] drop_count,
  input logic          rx_valid,
  input logic          rx_sof
);
  localparam int SW = DW / 2;
  localparam logic [SW-1:0] KNOWN = SW'((1 << ST_WRAP) | (1 << ST_LAST) | (1 << ST_ERR));

  // R9
  stall_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stalled |-> !mem_req);

  // R5
  own_return_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (mem_req && mem_we && !mem_wdata[SW + ST_EMPTY] && mem_wdata[SW + ST_LAST]));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R2
  status_clean_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ((mem_wdata[DW-1:SW] & ~KNOWN) == '0));

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (mem_wdata[SW-1:0] <= SW'(MAX_LEN)));

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |->
      ($past(rx_valid && rx_sof) && drop_count == $past(drop_count) + CW'(1)));

  // R4
  we_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.DW(DW), .CW(CW), .MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst(rst), .stalled(stalled), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .frame_done(frame_done), .drop_count(drop_count),
  .rx_valid(rx_valid), .rx_sof(rx_sof)
);

// File: tb/rxr_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rxr_ring_writer_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MAX_LEN = 1518;
  localparam int CW = 8;
  localparam int BASE = 16;
  localparam int B_EMPTY = 15, B_WRAP = 13, B_LAST = 11, B_ERR = 1;
  localparam logic [31:0] SENT = 32'hDEADBEEF;
  // vector: length[31:16], seed[15:8], error[0]
  localparam logic [31:0] VEC [6] = '{
    {16'd60, 8'h10, 8'd0}, {16'd61, 8'h40, 8'd0}, {16'd62, 8'h70, 8'd1},
    {16'd63, 8'hA0, 8'd0}, {16'd1,  8'hC5, 8'd0}, {16'd64, 8'h03, 8'd1}
  };

  logic clk = 1'b0, rst = 1'b1, kick = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = 8'h0;
  logic mem_req, mem_we, stalled, frame_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] drop_count;
  logic tb_we = 1'b0;
  logic [11:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;
  logic [31:0] mem [0:4095];
  int n_chk = 0, n_fail = 0, wcnt = 0, nxt = 0;

  always #2.5 clk = ~clk;

  rxr_ring_writer #(.AW(AW), .DW(DW), .MAX_LEN(MAX_LEN), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .ring_base(AW'(BASE)), .kick(kick),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stalled(stalled), .frame_done(frame_done), .drop_count(drop_count)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_req && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (mem_req) mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int buf_of(input int j);
    return 256 + 512 * j;
  endfunction

  function automatic logic [15:0] stat(input bit empty, input bit wrap, input bit last, input bit err);
    logic [15:0] s = '0;
    s[B_EMPTY] = empty; s[B_WRAP] = wrap; s[B_LAST] = last; s[B_ERR] = err;
    return s;
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = 12'(a); tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic free_desc(input int j);
    poke(BASE + 2 * j, {stat(1'b1, j == 2, 1'b0, 1'b0), 16'h0});
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic send(input int len, input logic [7:0] seed, input bit err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(seed + i);
      rx_sof = (i == 0); rx_eof = (i == len - 1); rx_err = err && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!frame_done);
    @(negedge clk);
  endtask

  task automatic check_frame(input int j, input int len, input logic [7:0] seed, input bit err, input string tag);
    int n, bad;
    logic [31:0] exp0, e, firstbad_a, firstbad_e;
    n = (len > MAX_LEN) ? MAX_LEN : len;
    exp0 = {stat(1'b0, j == 2, 1'b1, err || (len > MAX_LEN)), 16'(n)};
    chk(mem[BASE + 2 * j] == exp0, tag, mem[BASE + 2 * j], exp0, "descriptor word 0");
    chk(mem[BASE + 2 * j + 1] == 32'(buf_of(j)), "R2", mem[BASE + 2 * j + 1], 32'(buf_of(j)), "buffer pointer kept");
    bad = 0; firstbad_a = '0; firstbad_e = '0;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      e = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < n) e[8 * b +: 8] = 8'(seed + 4 * w + b);
      if (mem[buf_of(j) + w] != e) begin
        if (bad == 0) begin firstbad_a = mem[buf_of(j) + w]; firstbad_e = e; end
        bad++;
      end
    end
    chk(bad == 0, "R4", firstbad_a, firstbad_e, "buffer data");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired: actual %h expected %h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    logic [CW-1:0] d0;
    for (int j = 0; j < 3; j++) begin
      free_desc(j);
      poke(BASE + 2 * j + 1, 32'(buf_of(j)));
    end
    poke(buf_of(1) + 380, SENT);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(stalled == 1'b1, "R1", 32'(stalled), 1, "stalled after reset");
    chk(mem_req == 1'b0, "R1", 32'(mem_req), 0, "no request after reset");
    chk(drop_count == '0, "R1", 32'(drop_count), 0, "drop count after reset");
    // R1 R8: frame before any kick is dropped
    send(8, 8'h99, 1'b0);
    repeat (4) @(negedge clk);
    chk(drop_count == CW'(1), "R8", 32'(drop_count), 1, "drop before kick");
    chk(wcnt == 0, "R1", 32'(wcnt), 0, "no writes before kick");
    pulse_kick();
    repeat (8) @(negedge clk);
    chk(stalled == 1'b0, "R3", 32'(stalled), 0, "ready after kick");
    chk(wcnt == 0, "R3", 32'(wcnt), 0, "no writes while ready");
    // table of frames across the ring, freeing as it goes
    for (int i = 0; i < 6; i++) begin
      send(int'(VEC[i][31:16]), VEC[i][15:8], VEC[i][0]);
      wait_done();
      check_frame(nxt, int'(VEC[i][31:16]), VEC[i][15:8], VEC[i][0], (i >= 3) ? "R6" : "R5");
      free_desc(nxt);
      nxt = (nxt + 1) % 3;
      repeat (8) @(negedge clk);
    end
    // R9: fill the ring without freeing
    send(20, 8'h21, 1'b0); wait_done(); check_frame(0, 20, 8'h21, 1'b0, "R5"); repeat (8) @(negedge clk);
    send(21, 8'h31, 1'b0); wait_done(); check_frame(1, 21, 8'h31, 1'b0, "R5"); repeat (8) @(negedge clk);
    send(22, 8'h41, 1'b1); wait_done(); check_frame(2, 22, 8'h41, 1'b1, "R5");
    repeat (10) @(negedge clk);
    chk(stalled == 1'b1, "R9", 32'(stalled), 1, "stall on owned descriptor");
    w0 = wcnt; d0 = drop_count;
    send(16, 8'h51, 1'b0);
    repeat (4) @(negedge clk);
    chk(drop_count == d0 + CW'(1), "R8", 32'(drop_count), 32'(d0 + CW'(1)), "drop while stalled");
    chk(wcnt == w0, "R8", 32'(wcnt), 32'(w0), "no write for dropped frame");
    pulse_kick();
    repeat (10) @(negedge clk);
    chk(stalled == 1'b1, "R9", 32'(stalled), 1, "kick without freeing");
    chk(wcnt == w0, "R9", 32'(wcnt), 32'(w0), "no write after useless kick");
    free_desc(0);
    pulse_kick();
    repeat (8) @(negedge clk);
    chk(stalled == 1'b0, "R3", 32'(stalled), 0, "resume after freeing");
    send(33, 8'h5A, 1'b0); wait_done(); check_frame(0, 33, 8'h5A, 1'b0, "R9");
    repeat (8) @(negedge clk);
    free_desc(1); free_desc(2);
    pulse_kick();
    repeat (8) @(negedge clk);
    // R7 truncation into descriptor 1
    send(1530, 8'h07, 1'b0); wait_done();
    check_frame(1, 1530, 8'h07, 1'b0, "R7");
    chk(mem[buf_of(1) + 380] == SENT, "R7", mem[buf_of(1) + 380], SENT, "no write past truncated buffer");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule